// File: doc/BRIEF.md
# Debug Address Window Comparator

This block watches accesses on the processor bus and reports those whose address falls within, or beyond, a window set by a pair of address comparators. The lower comparator holds the window's low bound and the upper comparator holds its high bound. Both bounds are inclusive. A mode bit chooses the sense of the test. In inside mode an access hits when low <= address <= high. In outside mode an access hits when the address is below low or above high.

When data qualification is turned on, an address hit only counts if the access data also equals a compare value under a per-bit mask. Qualification works the same way on both sides of an outside window. Each qualified hit gives a one-cycle match pulse to the debug state sequencer. The pulse comes with the direction of the access that caused it.

The lower comparator's tag enable marks the window as reserved for tagging. While it is set, no forced match pulse comes out. The upper comparator's tag bit is present but has no effect in range operation.

Top module: `dbg_range_cmp`

## Requirements
- R1: While reset is held, and in the first cycle after reset is released, `match_o` is 0.
- R2: In inside mode (`cfg_outside`=0), an access pulses `match_o` exactly when `cfg_lo_addr` <= `bus_addr` <= `cfg_hi_addr`. Both bounds count as hits.
- R3: In outside mode (`cfg_outside`=1), an access pulses `match_o` exactly when `bus_addr` < `cfg_lo_addr` or `bus_addr` > `cfg_hi_addr`. The bounds themselves do not hit.
- R4: With `cfg_en`=0 no access produces a pulse, whatever its address.
- R5: With `cfg_dq_en`=1 a hit counts only if `(bus_data ^ cfg_data) & cfg_mask` is zero over the compared lanes. A mask bit of 0 makes that data bit don't-care. A word access (`bus_word`=1) compares all 16 bits.
- R6: A byte access (`bus_word`=0) compares one lane only. An even address uses bits [15:8] and an odd address uses bits [7:0]. The other lane is ignored.
- R7: In outside mode with qualification on, accesses above the high bound are qualified by data in the same way as accesses below the low bound. A data mismatch above the high bound gives no pulse.
- R8: With `cfg_tag_lo`=1 no pulse is produced. `cfg_tag_hi` has no effect, so with `cfg_tag_lo`=0 a set `cfg_tag_hi` never removes a valid pulse.
- R9: Hits in consecutive bus cycles each give their own pulse. This includes a write followed by a read of the same address and a misaligned (odd-address) word access. `match_rd_o` carries the `bus_rd` value of the access that caused each pulse.
- R10: `match_o` is registered. It rises one clock after the access is sampled, lasts one cycle unless the next cycle also hits, and is never high after a cycle with `bus_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Enables the window comparator |
| cfg_outside | input | 1 | 0: inside-window mode, 1: outside-window mode |
| cfg_dq_en | input | 1 | Enables data qualification |
| cfg_tag_lo | input | 1 | Lower comparator tag enable; suppresses forced matches |
| cfg_tag_hi | input | 1 | Upper comparator tag bit; ignored in range operation |
| cfg_lo_addr | input | 23 | Low bound, inclusive |
| cfg_hi_addr | input | 23 | High bound, inclusive |
| cfg_data | input | 16 | Data compare value |
| cfg_mask | input | 16 | Data compare mask, 1 = compare bit |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_addr | input | 23 | Access address |
| bus_data | input | 16 | Access data on its byte lanes |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_word | input | 1 | 1 = word access, 0 = byte access |
| match_o | output | 1 | Match pulse to the sequencer |
| match_rd_o | output | 1 | Direction of the access behind the pulse |

## Verification
Both outputs come from one register stage. An access driven before clock edge N therefore shows on `match_o` and `match_rd_o` right after edge N and no earlier. The bench drives every access on a falling edge and reads the result on the next falling edge. It also samples once shortly before the edge to confirm the pulse has not yet appeared. Back-to-back accesses are checked one per cycle, with no idle gap between them. This confirms that consecutive hits, including write-then-read and misaligned words, are not merged.

// File: rtl/dbg_range_cmp.sv
module dbg_range_cmp #(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_outside,
  input  logic              cfg_dq_en,
  input  logic              cfg_tag_lo,
  input  logic              cfg_tag_hi,
  input  logic [ADDR_W-1:0] cfg_lo_addr,
  input  logic [ADDR_W-1:0] cfg_hi_addr,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic [DATA_W-1:0] cfg_mask,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_rd,
  input  logic              bus_word,
  output logic              match_o,
  output logic              match_rd_o
);
  localparam int LANE_W = DATA_W / 2;
  localparam logic [LANE_W-1:0] LANE_ON  = '1;
  localparam logic [LANE_W-1:0] LANE_OFF = '0;

  logic              at_or_above_lo, at_or_below_hi, in_win, addr_hit;
  logic [DATA_W-1:0] lane_sel, diff;
  logic              data_ok, fire;

  assign at_or_above_lo = bus_addr >= cfg_lo_addr;
  assign at_or_below_hi = bus_addr <= cfg_hi_addr;
  assign in_win         = at_or_above_lo & at_or_below_hi;
  assign addr_hit       = cfg_outside ? ~in_win : in_win;

  always_comb begin
    if (bus_word)         lane_sel = {LANE_ON, LANE_ON};
    else if (bus_addr[0]) lane_sel = {LANE_OFF, LANE_ON};
    else                  lane_sel = {LANE_ON, LANE_OFF};
  end

  assign diff    = (bus_data ^ cfg_data) & cfg_mask & lane_sel;
  assign data_ok = ~cfg_dq_en | (diff == '0);
  assign fire    = bus_valid & cfg_en & addr_hit & data_ok & ~cfg_tag_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_o    <= 1'b0;
      match_rd_o <= 1'b0;
    end else begin
      match_o    <= fire;
      match_rd_o <= fire & bus_rd;
    end
  end

  // R10
  no_idle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !match_o);

  // R4
  disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !match_o);

  // R3
  outside_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && cfg_outside && bus_addr >= cfg_lo_addr && bus_addr <= cfg_hi_addr) |=> !match_o);

  // R8
  tag_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_tag_lo |=> !match_o);

  // R8
  tag_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && cfg_en && cfg_tag_hi && !cfg_tag_lo && !cfg_dq_en && !cfg_outside &&
     bus_addr >= cfg_lo_addr && bus_addr <= cfg_hi_addr) |=> match_o);

  // R9
  rd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_rd) |=> (match_rd_o == match_o));

endmodule

// File: tb/dbg_range_cmp_tb.sv
module dbg_range_cmp_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 1'b0, cfg_outside = 1'b0, cfg_dq_en = 1'b0;
  logic        cfg_tag_lo = 1'b0, cfg_tag_hi = 1'b0;
  logic [22:0] cfg_lo_addr = 23'h001000, cfg_hi_addr = 23'h001FFF;
  logic [15:0] cfg_data = 16'hA55A, cfg_mask = 16'hFFFF;
  logic        bus_valid = 1'b0;
  logic [22:0] bus_addr = '0;
  logic [15:0] bus_data = '0;
  logic        bus_rd = 1'b0, bus_word = 1'b1;
  logic        match_o, match_rd_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_range_cmp u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_en(cfg_en), .cfg_outside(cfg_outside), .cfg_dq_en(cfg_dq_en),
    .cfg_tag_lo(cfg_tag_lo), .cfg_tag_hi(cfg_tag_hi),
    .cfg_lo_addr(cfg_lo_addr), .cfg_hi_addr(cfg_hi_addr),
    .cfg_data(cfg_data), .cfg_mask(cfg_mask),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_rd(bus_rd), .bus_word(bus_word),
    .match_o(match_o), .match_rd_o(match_rd_o)
  );

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic acc(input logic [22:0] a, input logic [15:0] d, input logic rd,
                     input logic word, input logic exp, input string req);
    bus_valid = 1'b1; bus_addr = a; bus_data = d; bus_rd = rd; bus_word = word;
    @(negedge clk);
    chk(match_o, exp, req);
    if (exp) chk(match_rd_o, rd, req);
  endtask

  task automatic idle(input string req);
    bus_valid = 1'b0; bus_addr = 23'h001800; bus_data = cfg_data;
    @(negedge clk);
    chk(match_o, 1'b0, req);
  endtask

  task automatic t_reset();
    bus_valid = 1'b1; bus_addr = 23'h001800; cfg_en = 1'b1;
    repeat (3) @(negedge clk);
    chk(match_o, 1'b0, "R1 held");
    bus_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(match_o, 1'b0, "R1 released");
  endtask

  task automatic t_inside();
    cfg_en = 1'b1; cfg_outside = 1'b0; cfg_dq_en = 1'b0;
    acc(23'h000FFF, 16'h0, 1'b1, 1'b1, 1'b0, "R2 below");
    acc(23'h001000, 16'h0, 1'b1, 1'b1, 1'b1, "R2 low bound");
    acc(23'h001800, 16'h0, 1'b0, 1'b1, 1'b1, "R2 middle");
    acc(23'h001FFF, 16'h0, 1'b1, 1'b1, 1'b1, "R2 high bound");
    acc(23'h002000, 16'h0, 1'b1, 1'b1, 1'b0, "R2 above");
    idle("R10 idle");
  endtask

  task automatic t_outside();
    cfg_outside = 1'b1;
    acc(23'h000FFF, 16'h0, 1'b1, 1'b1, 1'b1, "R3 below");
    acc(23'h001000, 16'h0, 1'b1, 1'b1, 1'b0, "R3 low bound");
    acc(23'h001FFF, 16'h0, 1'b1, 1'b1, 1'b0, "R3 high bound");
    acc(23'h002000, 16'h0, 1'b0, 1'b1, 1'b1, "R3 above");
    acc(23'h7FFFFF, 16'h0, 1'b1, 1'b1, 1'b1, "R3 top");
    idle("R10 idle");
    cfg_outside = 1'b0;
  endtask

  task automatic t_disable();
    cfg_en = 1'b0;
    acc(23'h001800, 16'h0, 1'b1, 1'b1, 1'b0, "R4 disabled");
    cfg_en = 1'b1;
    idle("R10 idle");
  endtask

  task automatic t_dq();
    cfg_dq_en = 1'b1; cfg_mask = 16'hFFFF;
    acc(23'h001800, 16'hA55A, 1'b1, 1'b1, 1'b1, "R5 word equal");
    acc(23'h001800, 16'hA55B, 1'b1, 1'b1, 1'b0, "R5 word low byte differs");
    acc(23'h001800, 16'h255A, 1'b1, 1'b1, 1'b0, "R5 word high byte differs");
    cfg_mask = 16'hFF00;
    acc(23'h001800, 16'hA500, 1'b1, 1'b1, 1'b1, "R5 masked dont care");
    cfg_mask = 16'hFFFF;
    idle("R10 idle");
  endtask

  task automatic t_lane();
    acc(23'h001800, 16'hA511, 1'b1, 1'b0, 1'b1, "R6 even byte high lane");
    acc(23'h001800, 16'hB55A, 1'b1, 1'b0, 1'b0, "R6 even byte mismatch");
    acc(23'h001801, 16'h335A, 1'b1, 1'b0, 1'b1, "R6 odd byte low lane");
    acc(23'h001801, 16'hA55B, 1'b1, 1'b0, 1'b0, "R6 odd byte mismatch");
    idle("R10 idle");
  endtask

  task automatic t_outside_dq();
    cfg_outside = 1'b1;
    acc(23'h000800, 16'hA55A, 1'b1, 1'b1, 1'b1, "R7 below match");
    acc(23'h000800, 16'h0000, 1'b1, 1'b1, 1'b0, "R7 below mismatch");
    acc(23'h003000, 16'h0000, 1'b1, 1'b1, 1'b0, "R7 above mismatch");
    acc(23'h003000, 16'hA55A, 1'b1, 1'b1, 1'b1, "R7 above match");
    idle("R10 idle");
    cfg_outside = 1'b0; cfg_dq_en = 1'b0;
  endtask

  task automatic t_tag();
    cfg_tag_lo = 1'b1;
    acc(23'h001800, 16'h0, 1'b1, 1'b1, 1'b0, "R8 lower tag suppresses");
    cfg_tag_lo = 1'b0; cfg_tag_hi = 1'b1;
    acc(23'h001800, 16'h0, 1'b1, 1'b1, 1'b1, "R8 upper tag ignored");
    cfg_dq_en = 1'b1;
    acc(23'h001800, 16'hA55A, 1'b1, 1'b1, 1'b1, "R8 upper tag ignored qualified");
    cfg_dq_en = 1'b0; cfg_tag_hi = 1'b0;
    idle("R10 idle");
  endtask

  task automatic t_b2b();
    acc(23'h001802, 16'h1234, 1'b0, 1'b1, 1'b1, "R9 write");
    acc(23'h001802, 16'h1234, 1'b1, 1'b1, 1'b1, "R9 read same address");
    acc(23'h001803, 16'h5678, 1'b1, 1'b1, 1'b1, "R9 misaligned word");
    idle("R10 after burst");
    cfg_dq_en = 1'b1;
    acc(23'h001802, 16'hA55A, 1'b0, 1'b1, 1'b1, "R9 qualified write");
    acc(23'h001803, 16'hA55A, 1'b1, 1'b1, 1'b1, "R9 qualified misaligned read");
    cfg_dq_en = 1'b0;
    idle("R10 after burst");
  endtask

  task automatic t_latency();
    bus_valid = 1'b1; bus_addr = 23'h001800; bus_rd = 1'b1; bus_word = 1'b1;
    #(CLK_PERIOD/2 - 1);
    chk(match_o, 1'b0, "R10 not before edge");
    @(negedge clk);
    chk(match_o, 1'b1, "R10 after edge");
    bus_valid = 1'b0;
    @(negedge clk);
    chk(match_o, 1'b0, "R10 single cycle");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_inside();
    t_outside();
    t_disable();
    t_dq();
    t_lane();
    t_outside_dq();
    t_tag();
    t_b2b();
    t_latency();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule